// File: doc/BRIEF.md
# Breach-Driven Boost Accumulator

This block keeps a frequency boost that rises each time an activity monitor reports a run of samples above its upper watermark, and falls each time it reports a run below its lower watermark. When the boost grows, it is scaled by a programmable percentage and then a fixed step is added. The result is capped at a programmable maximum frequency. When the boost decays, it is scaled by a second percentage, and it snaps to zero once it drops below half the step. After every event the block also decides which of the two breach detectors should be armed again. It then forms a target frequency from the sampled average activity count, the sampling period, the upper threshold and the new boost.

Each event arrives on a valid/ready input along with its configuration. The arithmetic runs on one shared sequential multiply-then-divide unit. The result comes out on a valid/ready output, and the block accepts no event while a result is pending. `evt_ready` is high only when the block is idle. An event is taken on a clock edge where `evt_valid` and `evt_ready` are both high, and all event and configuration inputs are captured on that edge. `res_valid` then stays high, with `boost`, the arm flags and `target` held stable, until a clock edge where `res_ready` is high. The block returns to idle after that edge. Back-pressure on the output therefore stalls the input.

Top module: `boost_acc`

## Requirements
- R1: After reset, `boost` and `target` are 0, `arm_above` and `arm_below` are 1, `evt_ready` is 1 and `res_valid` is 0.
- R2: For an event with `evt_up`=1, the new boost is floor(old × `up_coeff` / 100) + STEP, where STEP defaults to 16000. The product is computed without truncation.
- R3: For an up event, if the grown value is at or above `max_freq`, the boost becomes `max_freq` and `arm_above` becomes 0. Otherwise `arm_above` becomes 1. An up event always sets `arm_below` to 1.
- R4: For an event with `evt_down`=1 and `evt_up`=0, the new boost is floor(old × `down_coeff` / 100) and `arm_above` becomes 1. If that value is below STEP/2, the boost becomes 0 and `arm_below` becomes 0. Otherwise `arm_below` becomes 1.
- R5: When `evt_up` and `evt_down` are both 1, the event is handled as an up event only.
- R6: An event with both flags at 0 leaves `boost` and `arm_above` unchanged. It leaves `arm_below` unchanged unless R7 applies.
- R7: When `dep_thresh` is nonzero, it adjusts `arm_below` after R3 to R6 have been applied. An average at or above `dep_thresh` sets `arm_below` to 1. An average below it, with a new boost of 0, clears `arm_below` to 0. When `dep_thresh` is 0, this rule does nothing.
- R8: `target` = floor(floor(`avg_count`/`sample_period`) × floor(10000/`up_thresh`) / 100) + new boost, truncated to FW bits.
- R9: `evt_ready` and `res_valid` are never high together. While `res_valid` is high and `res_ready` is low, `boost`, `target` and both arm flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_valid | input | 1 | Event offered |
| evt_ready | output | 1 | Block idle, event can be taken |
| evt_up | input | 1 | Upper-watermark run detected |
| evt_down | input | 1 | Lower-watermark run detected |
| avg_count | input | FW | Sampled average activity count |
| up_coeff | input | CW | Growth factor, percent |
| down_coeff | input | CW | Decay factor, percent (at most 100) |
| up_thresh | input | CW | Upper watermark threshold, percent, nonzero |
| dep_thresh | input | FW | Activity dependency threshold, 0 disables |
| sample_period | input | FW | Sampling period, nonzero |
| max_freq | input | FW | Boost ceiling |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| boost | output | FW | Current boost |
| arm_above | output | 1 | Upper breach detector stays armed |
| arm_below | output | 1 | Lower breach detector stays armed |
| target | output | FW | Target frequency |

## Verification
Some properties are checked by assertions on every cycle. The output handshake never overlaps with input readiness, and a held result does not move under back-pressure. After an up event, the boost never exceeds the captured ceiling and the lower detector is armed. After a down-only event, the upper detector is armed. The multiply-divide unit is never started while busy. Other behaviour can only be shown by the directed scenarios: the exact growth and decay values, the saturation point, the snap to zero, the priority of up over down, the dependency rule and the target formula, each compared against values the bench computes itself.

// File: rtl/boost_acc_pkg.sv
package boost_acc_pkg;

  typedef enum logic [1:0] {
    CTL_IDLE,
    CTL_LAUNCH,
    CTL_WAIT,
    CTL_HOLD
  } ctl_state_t;

  typedef enum logic [1:0] {
    OP_SCALE,
    OP_RATE,
    OP_COEF,
    OP_TGT
  } calc_op_t;

  typedef enum logic [1:0] {
    MD_IDLE,
    MD_MUL,
    MD_DIV
  } md_phase_t;

  localparam int unsigned PCT_FULL  = 100;
  localparam int unsigned PCT_SQ    = 10000;

endpackage

// File: rtl/boost_muldiv.sv
module boost_muldiv #(
  parameter int AW = 32,
  parameter int BW = 16,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    op_a,
  input  logic [BW-1:0]    op_b,
  input  logic [DW-1:0]    op_d,
  output logic             busy,
  output logic             done,
  output logic [AW+BW-1:0] quo
);
  import boost_acc_pkg::*;

  localparam int PW   = AW + BW;
  localparam int CNTW = $clog2(PW + 1);
  localparam logic [CNTW-1:0] MUL_LAST = CNTW'(BW - 1);
  localparam logic [CNTW-1:0] DIV_LAST = CNTW'(PW - 1);

  md_phase_t       ph;
  logic [PW-1:0]   acc;
  logic [PW-1:0]   mcand;
  logic [BW-1:0]   mplier;
  logic [DW-1:0]   dv;
  logic [DW-1:0]   rem;
  logic [CNTW-1:0] cnt;

  logic [DW:0]     trial;
  logic            fits;
  logic [DW-1:0]   diff;

  always_comb begin
    trial = {rem, acc[PW-1]};
    fits  = (trial >= {1'b0, dv});
    diff  = trial[DW-1:0] - dv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= MD_IDLE;
      acc    <= '0;
      mcand  <= '0;
      mplier <= '0;
      dv     <= '0;
      rem    <= '0;
      cnt    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (ph)
        MD_IDLE: begin
          if (start) begin
            acc    <= '0;
            mcand  <= PW'(op_a);
            mplier <= op_b;
            dv     <= op_d;
            cnt    <= '0;
            ph     <= MD_MUL;
          end
        end
        MD_MUL: begin
          if (mplier[0]) acc <= acc + mcand;
          mcand  <= mcand << 1;
          mplier <= mplier >> 1;
          if (cnt == MUL_LAST) begin
            cnt <= '0;
            rem <= '0;
            ph  <= MD_DIV;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        MD_DIV: begin
          if (fits) begin
            rem <= diff;
            acc <= {acc[PW-2:0], 1'b1};
          end else begin
            rem <= trial[DW-1:0];
            acc <= {acc[PW-2:0], 1'b0};
          end
          if (cnt == DIV_LAST) begin
            ph   <= MD_IDLE;
            done <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ph <= MD_IDLE;
      endcase
    end
  end

  assign busy = (ph != MD_IDLE);
  assign quo  = acc;

  // R9: a new operation is only launched on an idle unit
  p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

endmodule

// File: rtl/boost_decide.sv
module boost_decide #(
  parameter int FW   = 32,
  parameter int PW   = 48,
  parameter int STEP = 16000
) (
  input  logic          go_up,
  input  logic          go_down,
  input  logic [FW-1:0] old_boost,
  input  logic [PW-1:0] scaled,
  input  logic [FW-1:0] ceiling,
  input  logic [FW-1:0] avg,
  input  logic [FW-1:0] dep_level,
  input  logic          above_in,
  input  logic          below_in,
  output logic [FW-1:0] boost_out,
  output logic          above_out,
  output logic          below_out
);
  localparam logic [PW:0]   STEP_W = (PW+1)'(STEP);
  localparam logic [PW-1:0] HALF_W = PW'(STEP / 2);

  logic [PW:0] grown;
  logic        saturate;
  logic        to_zero;

  always_comb begin
    grown    = {1'b0, scaled} + STEP_W;
    saturate = (grown >= (PW+1)'(ceiling));
    to_zero  = (scaled < HALF_W);

    boost_out = old_boost;
    above_out = above_in;
    below_out = below_in;

    if (go_up) begin
      below_out = 1'b1;
      if (saturate) begin
        boost_out = ceiling;
        above_out = 1'b0;
      end else begin
        boost_out = grown[FW-1:0];
        above_out = 1'b1;
      end
    end else if (go_down) begin
      above_out = 1'b1;
      if (to_zero) begin
        boost_out = '0;
        below_out = 1'b0;
      end else begin
        boost_out = scaled[FW-1:0];
        below_out = 1'b1;
      end
    end

    if (dep_level != '0) begin
      if (avg >= dep_level)
        below_out = 1'b1;
      else if (boost_out == '0)
        below_out = 1'b0;
    end
  end

endmodule

// File: rtl/boost_acc.sv
module boost_acc #(
  parameter int FW   = 32,
  parameter int CW   = 10,
  parameter int MW   = 16,
  parameter int STEP = 16000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_valid,
  output logic          evt_ready,
  input  logic          evt_up,
  input  logic          evt_down,
  input  logic [FW-1:0] avg_count,
  input  logic [CW-1:0] up_coeff,
  input  logic [CW-1:0] down_coeff,
  input  logic [CW-1:0] up_thresh,
  input  logic [FW-1:0] dep_thresh,
  input  logic [FW-1:0] sample_period,
  input  logic [FW-1:0] max_freq,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [FW-1:0] boost,
  output logic          arm_above,
  output logic          arm_below,
  output logic [FW-1:0] target
);
  import boost_acc_pkg::*;

  localparam int PW = FW + MW;

  ctl_state_t    st;
  calc_op_t      op_q;

  logic          k_up, k_dn;
  logic [FW-1:0] avg_q, dep_q, per_q, max_q;
  logic [CW-1:0] upc_q, dnc_q, upth_q;
  logic [FW-1:0] boost_q, rate_q, tgt_q;
  logic [MW-1:0] coef_q;
  logic          above_q, below_q;

  logic          md_start, md_busy, md_done;
  logic [FW-1:0] md_a, md_d;
  logic [MW-1:0] md_b;
  logic [PW-1:0] md_quo;

  logic [FW-1:0] nb_boost;
  logic          nb_above, nb_below;

  logic          accept;
  assign accept = evt_valid && (st == CTL_IDLE);

  always_comb begin
    md_a = '0;
    md_b = '0;
    md_d = '0;
    case (op_q)
      OP_SCALE: begin
        md_a = boost_q;
        md_b = k_up ? MW'(upc_q) : (k_dn ? MW'(dnc_q) : MW'(PCT_FULL));
        md_d = FW'(PCT_FULL);
      end
      OP_RATE: begin
        md_a = avg_q;
        md_b = MW'(1);
        md_d = per_q;
      end
      OP_COEF: begin
        md_a = FW'(PCT_SQ);
        md_b = MW'(1);
        md_d = FW'(upth_q);
      end
      default: begin
        md_a = rate_q;
        md_b = coef_q;
        md_d = FW'(PCT_FULL);
      end
    endcase
  end

  assign md_start = (st == CTL_LAUNCH);

  boost_muldiv #(.AW(FW), .BW(MW), .DW(FW)) md_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (md_start),
    .op_a  (md_a),
    .op_b  (md_b),
    .op_d  (md_d),
    .busy  (md_busy),
    .done  (md_done),
    .quo   (md_quo)
  );

  boost_decide #(.FW(FW), .PW(PW), .STEP(STEP)) dec_i (
    .go_up     (k_up),
    .go_down   (k_dn),
    .old_boost (boost_q),
    .scaled    (md_quo),
    .ceiling   (max_q),
    .avg       (avg_q),
    .dep_level (dep_q),
    .above_in  (above_q),
    .below_in  (below_q),
    .boost_out (nb_boost),
    .above_out (nb_above),
    .below_out (nb_below)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= CTL_IDLE;
      op_q    <= OP_SCALE;
      k_up    <= 1'b0;
      k_dn    <= 1'b0;
      avg_q   <= '0;
      dep_q   <= '0;
      per_q   <= '0;
      max_q   <= '0;
      upc_q   <= '0;
      dnc_q   <= '0;
      upth_q  <= '0;
      boost_q <= '0;
      rate_q  <= '0;
      coef_q  <= '0;
      tgt_q   <= '0;
      above_q <= 1'b1;
      below_q <= 1'b1;
    end else begin
      case (st)
        CTL_IDLE: begin
          if (accept) begin
            k_up   <= evt_up;
            k_dn   <= evt_down;
            avg_q  <= avg_count;
            dep_q  <= dep_thresh;
            per_q  <= sample_period;
            max_q  <= max_freq;
            upc_q  <= up_coeff;
            dnc_q  <= down_coeff;
            upth_q <= up_thresh;
            op_q   <= OP_SCALE;
            st     <= CTL_LAUNCH;
          end
        end
        CTL_LAUNCH: st <= CTL_WAIT;
        CTL_WAIT: begin
          if (md_done) begin
            case (op_q)
              OP_SCALE: begin
                boost_q <= nb_boost;
                above_q <= nb_above;
                below_q <= nb_below;
                op_q    <= OP_RATE;
                st      <= CTL_LAUNCH;
              end
              OP_RATE: begin
                rate_q <= md_quo[FW-1:0];
                op_q   <= OP_COEF;
                st     <= CTL_LAUNCH;
              end
              OP_COEF: begin
                coef_q <= md_quo[MW-1:0];
                op_q   <= OP_TGT;
                st     <= CTL_LAUNCH;
              end
              default: begin
                tgt_q <= md_quo[FW-1:0] + boost_q;
                st    <= CTL_HOLD;
              end
            endcase
          end
        end
        CTL_HOLD: if (res_ready) st <= CTL_IDLE;
        default: st <= CTL_IDLE;
      endcase
    end
  end

  assign evt_ready = (st == CTL_IDLE);
  assign res_valid = (st == CTL_HOLD);
  assign boost     = boost_q;
  assign arm_above = above_q;
  assign arm_below = below_q;
  assign target    = tgt_q;

  // R9: input readiness and output validity never overlap
  p_ready_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_ready && res_valid));

  // R9: a stalled result holds every output
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(target) && $stable(boost)
      && $stable(arm_above) && $stable(arm_below)));

  // R3: after an up event the boost sits at or below the captured ceiling
  p_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && k_up) |-> (boost <= max_q));

  // R3: an up event leaves the lower detector armed
  p_up_arms_below_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && k_up) |-> arm_below);

  // R4: a down-only event leaves the upper detector armed
  p_down_arms_above_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && k_dn && !k_up) |-> arm_above);

  // R9: no state moves while idle with nothing offered
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ready && !evt_valid) |=> ($stable(boost) && $stable(arm_above) && $stable(arm_below)));

  // R6: no stray multiply-divide activity while idle
  p_idle_unit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ready |-> !md_busy);

endmodule

// File: tb/boost_acc_tb_top.sv
module boost_acc_tb_top;
  localparam int FW = 32;
  localparam int CW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          evt_valid = 1'b0;
  logic          evt_ready;
  logic          evt_up = 1'b0;
  logic          evt_down = 1'b0;
  logic [FW-1:0] avg_count = '0;
  logic [CW-1:0] up_coeff = '0;
  logic [CW-1:0] down_coeff = '0;
  logic [CW-1:0] up_thresh = '0;
  logic [FW-1:0] dep_thresh = '0;
  logic [FW-1:0] sample_period = '0;
  logic [FW-1:0] max_freq = '0;
  logic          res_valid;
  logic          res_ready = 1'b0;
  logic [FW-1:0] boost;
  logic          arm_above;
  logic          arm_below;
  logic [FW-1:0] target;

  int checks = 0;
  int errors = 0;

  longint m_boost = 0;
  bit     m_above = 1'b1;
  bit     m_below = 1'b1;

  boost_acc dut_i (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_up(evt_up), .evt_down(evt_down), .avg_count(avg_count),
    .up_coeff(up_coeff), .down_coeff(down_coeff), .up_thresh(up_thresh),
    .dep_thresh(dep_thresh), .sample_period(sample_period), .max_freq(max_freq),
    .res_valid(res_valid), .res_ready(res_ready), .boost(boost),
    .arm_above(arm_above), .arm_below(arm_below), .target(target)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic configure(input int upc, input int dnc, input int upth,
                           input longint dep, input longint per, input longint mx);
    up_coeff      = CW'(upc);
    down_coeff    = CW'(dnc);
    up_thresh     = CW'(upth);
    dep_thresh    = FW'(dep);
    sample_period = FW'(per);
    max_freq      = FW'(mx);
  endtask

  // Reference behaviour built from the requirements
  function automatic longint model_step(input bit up, input bit dn, input longint avg);
    longint nb;
    longint rate;
    longint coef;
    nb = m_boost;
    if (up) begin
      nb = m_boost * longint'(up_coeff) / 100 + 16000;
      m_below = 1'b1;
      if (nb >= longint'(max_freq)) begin
        nb = longint'(max_freq);
        m_above = 1'b0;
      end else begin
        m_above = 1'b1;
      end
    end else if (dn) begin
      nb = m_boost * longint'(down_coeff) / 100;
      m_above = 1'b1;
      if (nb < 8000) begin
        nb = 0;
        m_below = 1'b0;
      end else begin
        m_below = 1'b1;
      end
    end
    if (dep_thresh != 0) begin
      if (avg >= longint'(dep_thresh)) m_below = 1'b1;
      else if (nb == 0) m_below = 1'b0;
    end
    m_boost = nb;
    rate = avg / longint'(sample_period);
    coef = 10000 / longint'(up_thresh);
    return ((rate * coef / 100) + nb) & 64'hFFFF_FFFF;
  endfunction

  // Offers one event, waits for the result, checks it, and optionally stalls it
  task automatic run_event(input string req, input bit up, input bit dn,
                           input longint avg, input int stall);
    longint exp_t;
    logic [FW-1:0] held_t;
    exp_t = model_step(up, dn, avg);
    @(negedge clk);
    evt_up    = up;
    evt_down  = dn;
    avg_count = FW'(avg);
    evt_valid = 1'b1;
    while (!evt_ready) @(negedge clk);
    @(negedge clk);
    evt_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    chk({req, " boost"}, longint'(boost), m_boost);
    chk({req, " arm_above"}, longint'(arm_above), longint'(m_above));
    chk({req, " arm_below"}, longint'(arm_below), longint'(m_below));
    chk({"R8 target after ", req}, longint'(target), exp_t);
    chk("R9 ready low while result pending", longint'(evt_ready), 0);
    if (stall > 0) begin
      held_t = target;
      repeat (stall) @(negedge clk);
      chk("R9 result held under back-pressure", longint'(res_valid), 1);
      chk("R9 target stable under back-pressure", longint'(target), longint'(held_t));
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk("R9 ready after result taken", longint'(evt_ready), 1);
  endtask

  task automatic t_reset;
    chk("R1 boost at reset", longint'(boost), 0);
    chk("R1 target at reset", longint'(target), 0);
    chk("R1 arm_above at reset", longint'(arm_above), 1);
    chk("R1 arm_below at reset", longint'(arm_below), 1);
    chk("R1 evt_ready at reset", longint'(evt_ready), 1);
    chk("R1 res_valid at reset", longint'(res_valid), 0);
  endtask

  task automatic t_growth;
    configure(200, 50, 60, 0, 12, 200000);
    run_event("R2 first growth", 1'b1, 1'b0, 120000, 0);
    run_event("R2 second growth", 1'b1, 1'b0, 240000, 0);
    run_event("R2 third growth", 1'b1, 1'b0, 36000, 0);
    chk("R2 value after three steps", longint'(boost), 112000);
  endtask

  task automatic t_clamp;
    run_event("R3 saturating growth", 1'b1, 1'b0, 120000, 0);
    chk("R3 clamped to ceiling", longint'(boost), 200000);
    chk("R3 upper detector disarmed", longint'(arm_above), 0);
  endtask

  task automatic t_decay;
    for (int i = 0; i < 4; i++) run_event("R4 decay", 1'b0, 1'b1, 60000, 0);
    chk("R4 value after four halvings", longint'(boost), 12500);
    run_event("R4 snap to zero", 1'b0, 1'b1, 60000, 0);
    chk("R4 boost zeroed", longint'(boost), 0);
    chk("R4 lower detector disarmed", longint'(arm_below), 0);
  endtask

  task automatic t_neither;
    run_event("R6 no-flag event", 1'b0, 1'b0, 90000, 0);
    chk("R6 lower detector still disarmed", longint'(arm_below), 0);
  endtask

  task automatic t_priority;
    run_event("R5 both flags", 1'b1, 1'b1, 60000, 0);
    chk("R5 handled as growth", longint'(boost), 16000);
  endtask

  task automatic t_second_set;
    configure(800, 90, 27, 50000, 12, 200000);
    run_event("R2 large coefficient growth", 1'b1, 1'b0, 120000, 0);
    chk("R2 value with 800 percent", longint'(boost), 144000);
    run_event("R3 large coefficient clamp", 1'b1, 1'b0, 120000, 0);
    run_event("R4 decay at 90 percent", 1'b0, 1'b1, 30000, 0);
    chk("R4 value at 90 percent", longint'(boost), 180000);
  endtask

  task automatic t_dependency;
    m_boost = m_boost;
    configure(800, 10, 27, 50000, 12, 200000);
    run_event("R7 decay below threshold", 1'b0, 1'b1, 20000, 0);
    run_event("R7 decay to zero below threshold", 1'b0, 1'b1, 20000, 0);
    chk("R7 disarmed with zero boost", longint'(arm_below), 0);
    run_event("R7 high activity rearms", 1'b0, 1'b0, 60000, 0);
    chk("R7 armed at high activity", longint'(arm_below), 1);
    run_event("R7 low activity zero boost", 1'b0, 1'b0, 49999, 0);
    chk("R7 disarmed at low activity", longint'(arm_below), 0);
    run_event("R7 at exact threshold", 1'b0, 1'b1, 50000, 0);
    chk("R7 armed at exact threshold", longint'(arm_below), 1);
  endtask

  task automatic t_backpressure;
    configure(200, 50, 40, 0, 10, 500000);
    run_event("R9 stalled growth", 1'b1, 1'b0, 77777, 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_growth();
    t_clamp();
    t_decay();
    t_neither();
    t_priority();
    t_second_set();
    t_dependency();
    t_backpressure();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired, no result");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule